// File: doc/BRIEF.md
# Power-Fail Write Guard With Battery-Status Flag

This block stands between a byte-wide host bus (active-low chip enable, write enable and output enable, plus address and write data) and an on-chip static RAM. It forwards accesses to the array with one register stage. Two supply-monitor decisions, arriving as digital levels, control what gets through.

When the power-fail level is active, the array is deselected. No write strobe reaches it, the read-data drivers are released to high impedance, and the captured address and write data freeze. Host bus activity during that time has no effect.

A battery-status flag is loaded from the battery-low level whenever a power-up strobe arrives. While the flag is set, the next write pulse is swallowed whole and the flag clears itself. Reads are never affected by the flag. Software can therefore find a weak battery by reading a byte, writing back its complement and reading it again. If the byte did not change, the flag was set.

Top module: `pwrfail_guard`

## Requirements
- R1: A read (bus_ce_n=0, bus_oe_n=0, bus_we_n=1 sampled on an edge) raises rd_drive_en and mem_ce on the following edge. Without power fail, this holds whatever the value of batt_bad.
- R2: A write pulse (bus_ce_n=0, bus_we_n=0) that is not blocked raises mem_we one edge after it is sampled and holds it for as long as the pulse lasts. mem_addr and mem_wdata carry the bus values sampled with it. mem_we and rd_drive_en are never high together.
- R3: After power_fail_in has passed through SYNC_STAGES synchroniser flops, mem_we, mem_ce and rd_drive_en are held low on the next edge. mem_addr and mem_wdata stay frozen, and all bus inputs are ignored for as long as the fail level lasts.
- R4: A power fail that arrives during a write ends mem_we on the next edge after the synchronised fail level. If the fail clears while bus_we_n is still held low, mem_we does not resume; only a new falling edge of bus_we_n starts a new write.
- R5: A one-cycle pwr_up_stb loads batt_bad with the synchronised battery-low level (1 = battery not OK).
- R6: While batt_bad is 1, the whole of the next write pulse is blocked (mem_we stays 0), and batt_bad returns to 0 at the start of that pulse.
- R7: Once the flag has cleared, later writes proceed as in R2.
- R8: A write attempt is counted once per falling edge of bus_we_n with bus_ce_n low. A long pulse counts once, and bus_we_n low with bus_ce_n high is not an attempt and leaves batt_bad unchanged.
- R9: pwr_up_stb is ignored while the synchronised power-fail level is active.
- R10: Reset clears batt_bad and all outputs, and releases any deselect.
- R11: batt_low_in has no effect on batt_bad except on a pwr_up_stb cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| power_fail_in | input | 1 | Supply-fail decision, asynchronous level |
| pwr_up_stb | input | 1 | One-cycle power-up strobe, synchronous |
| batt_low_in | input | 1 | Battery-low decision, asynchronous level |
| bus_addr | input | ADDR_W | Host address |
| bus_wdata | input | DATA_W | Host write data |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| mem_addr | output | ADDR_W | Address presented to the array |
| mem_wdata | output | DATA_W | Write data presented to the array |
| mem_ce | output | 1 | Array select |
| mem_we | output | 1 | Gated array write strobe |
| rd_drive_en | output | 1 | Enable for the tristate read-data drivers |
| batt_bad | output | 1 | Battery-not-OK status |

## Verification
The bench builds the block with SYNC_STAGES=3, ADDR_W=6 and DATA_W=8. The deeper synchroniser moves the power-fail and battery-low latency away from the default. This shows up any latency that was hard-coded to two stages rather than derived from the parameter. A reference model fed by delay queues follows every edge through the fail-during-write abort, the blocked first write, strobes during a fail, and a random mix of bus cycles.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

  typedef struct packed {
    logic ce;
    logic we;
    logic oe;
  } bus_ctl_t;

  function automatic bus_ctl_t decode_ctl(input logic ce_n, input logic we_n,
                                          input logic oe_n);
    bus_ctl_t c;
    c.ce = ~ce_n;
    c.we = ~we_n;
    c.oe = ~oe_n;
    return c;
  endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/pfg_bus_sample.sv
module pfg_bus_sample
  import pfg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  output bus_ctl_t          ctl,
  output logic              we_prev,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);

  bus_ctl_t          ctl_d;
  logic              we_prev_d;

  always_comb begin
    ctl_d     = decode_ctl(bus_ce_n, bus_we_n, bus_oe_n);
    we_prev_d = ctl.we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      we_prev <= 1'b0;
      addr    <= '0;
      wdata   <= '0;
    end else begin
      ctl     <= ctl_d;
      we_prev <= we_prev_d;
      addr    <= bus_addr;
      wdata   <= bus_wdata;
    end
  end

endmodule

// File: rtl/pfg_wr_guard.sv
module pfg_wr_guard
  import pfg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bus_ctl_t ctl,
  input  logic     we_prev,
  input  logic     pf_s,
  input  logic     batt_s,
  input  logic     pwr_up,
  output logic     wr_start,
  output logic     wr_ok,
  output logic     flag
);

  logic wr_held;
  logic act_q;
  logic act_d;
  logic flag_d;
  logic load_en;

  always_comb begin
    wr_held  = ctl.ce & ctl.we & ~pf_s;
    wr_start = wr_held & ~we_prev;
    wr_ok    = wr_held & ((wr_start & ~flag) | act_q);
    load_en  = pwr_up & ~pf_s;

    if (!wr_held) begin
      act_d = 1'b0;
    end else if (wr_start && !flag) begin
      act_d = 1'b1;
    end else begin
      act_d = act_q;
    end

    if (load_en) begin
      flag_d = batt_s;
    end else if (wr_start) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      act_q <= act_d;
      flag  <= flag_d;
    end
  end

endmodule

// File: rtl/pfg_out_stage.sv
module pfg_out_stage
  import pfg_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ctl_t          ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pf_s,
  input  logic              wr_ok,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_ce,
  output logic              mem_we,
  output logic              rd_drive_en
);

  logic addr_en;
  logic data_en;
  logic ce_d;
  logic rd_d;

  always_comb begin
    addr_en = ctl.ce & ~pf_s;
    data_en = wr_ok;
    ce_d    = ctl.ce & ~pf_s;
    rd_d    = ctl.ce & ctl.oe & ~ctl.we & ~pf_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ce      <= 1'b0;
      mem_we      <= 1'b0;
      rd_drive_en <= 1'b0;
    end else begin
      mem_ce      <= ce_d;
      mem_we      <= wr_ok;
      rd_drive_en <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
    end else if (addr_en) begin
      mem_addr <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wdata <= '0;
    end else if (data_en) begin
      mem_wdata <= wdata;
    end
  end

endmodule

// File: rtl/pwrfail_guard.sv
module pwrfail_guard
  import pfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              power_fail_in,
  input  logic              pwr_up_stb,
  input  logic              batt_low_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_ce,
  output logic              mem_we,
  output logic              rd_drive_en,
  output logic              batt_bad
);

  logic              pf_s;
  logic              batt_s;
  bus_ctl_t          ctl;
  logic              we_prev;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_start;
  logic              wr_ok;

  pfg_sync #(.STAGES(SYNC_STAGES)) u_pf_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (power_fail_in),
    .q    (pf_s)
  );

  pfg_sync #(.STAGES(SYNC_STAGES)) u_batt_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (batt_low_in),
    .q    (batt_s)
  );

  pfg_bus_sample #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sample (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_ce_n (bus_ce_n),
    .bus_we_n (bus_we_n),
    .bus_oe_n (bus_oe_n),
    .ctl      (ctl),
    .we_prev  (we_prev),
    .addr     (addr_q),
    .wdata    (wdata_q)
  );

  pfg_wr_guard u_guard (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .we_prev (we_prev),
    .pf_s    (pf_s),
    .batt_s  (batt_s),
    .pwr_up  (pwr_up_stb),
    .wr_start(wr_start),
    .wr_ok   (wr_ok),
    .flag    (batt_bad)
  );

  pfg_out_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .addr       (addr_q),
    .wdata      (wdata_q),
    .pf_s       (pf_s),
    .wr_ok      (wr_ok),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ce     (mem_ce),
    .mem_we     (mem_we),
    .rd_drive_en(rd_drive_en)
  );

endmodule

// File: rtl/pfg_checker.sv
module pfg_checker #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pf_sync,
  input logic              wr_start,
  input logic              pwr_up,
  input logic              flag,
  input logic              mem_we,
  input logic              mem_ce,
  input logic              rd_drive_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata
);

  a_r3_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    pf_sync |=> (!mem_we && !mem_ce && !rd_drive_en));

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    pf_sync |=> ($stable(mem_addr) && $stable(mem_wdata)));

  a_r6_block_first: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && flag) |=> !mem_we);

  a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && !pwr_up) |=> !flag);

  a_r9_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up && pf_sync && !wr_start) |=> $stable(flag));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && rd_drive_en));

endmodule

bind pwrfail_guard pfg_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pf_sync    (pf_s),
  .wr_start   (wr_start),
  .pwr_up     (pwr_up_stb),
  .flag       (batt_bad),
  .mem_we     (mem_we),
  .mem_ce     (mem_ce),
  .rd_drive_en(rd_drive_en),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/pwrfail_guard_bench.sv
module pwrfail_guard_bench;

  localparam int CLK_P = 10;
  localparam int NS    = 3;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int WDOG  = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pf_in = 1'b0;
  logic          pwr_up = 1'b0;
  logic          bl_in = 1'b0;
  logic [AW-1:0] b_addr = '0;
  logic [DW-1:0] b_data = '0;
  logic          ce_n = 1'b1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata;
  logic          m_ce;
  logic          m_we;
  logic          rd_en;
  logic          bad_flag;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R10";

  // reference model state
  bit      pq[$];
  bit      bq[$];
  bit      r_pf, r_bt;
  bit      s_ce, s_we, s_oe, s_prev;
  int      s_addr, s_data;
  bit      r_act, r_flag;
  bit      e_we, e_ce, e_rd;
  int      e_addr, e_data;

  always #(CLK_P/2) clk = ~clk;

  pwrfail_guard #(.SYNC_STAGES(NS), .ADDR_W(AW), .DATA_W(DW)) u_pwrfail_guard (
    .clk(clk), .rst_n(rst_n), .power_fail_in(pf_in), .pwr_up_stb(pwr_up),
    .batt_low_in(bl_in), .bus_addr(b_addr), .bus_wdata(b_data),
    .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .mem_addr(m_addr), .mem_wdata(m_wdata), .mem_ce(m_ce), .mem_we(m_we),
    .rd_drive_en(rd_en), .batt_bad(bad_flag)
  );

  task automatic model_reset();
    pq.delete(); bq.delete();
    for (int i = 0; i < NS; i++) begin pq.push_back(1'b0); bq.push_back(1'b0); end
    r_pf = 0; r_bt = 0; s_ce = 0; s_we = 0; s_oe = 0; s_prev = 0;
    s_addr = 0; s_data = 0; r_act = 0; r_flag = 0;
    e_we = 0; e_ce = 0; e_rd = 0; e_addr = 0; e_data = 0;
  endtask

  task automatic model_edge();
    bit start, held;
    if (!rst_n) begin model_reset(); return; end
    held  = s_ce && s_we && !r_pf;
    start = held && !s_prev;
    e_we  = held && ((start && !r_flag) || r_act);
    e_ce  = s_ce && !r_pf;
    e_rd  = s_ce && s_oe && !s_we && !r_pf;
    if (s_ce && !r_pf) e_addr = s_addr;
    if (e_we) e_data = s_data;
    if (!held) r_act = 0; else if (start && !r_flag) r_act = 1;
    if (pwr_up && !r_pf) r_flag = r_bt; else if (start) r_flag = 0;
    s_prev = s_we;
    s_ce = !ce_n; s_we = !we_n; s_oe = !oe_n;
    s_addr = int'(b_addr); s_data = int'(b_data);
    pq.push_front(pf_in); void'(pq.pop_back()); r_pf = pq[NS-1];
    bq.push_front(bl_in); void'(bq.pop_back()); r_bt = bq[NS-1];
  endtask

  task automatic compare();
    total++;
    if (m_we !== e_we || m_ce !== e_ce || rd_en !== e_rd || bad_flag !== r_flag ||
        int'(m_addr) != e_addr || int'(m_wdata) != e_data) begin
      bad++;
      $display("FAIL %s: we/ce/rd/flag/addr/data actual=%0b%0b%0b%0b/%0h/%0h expected=%0b%0b%0b%0b/%0h/%0h",
               cur_req, m_we, m_ce, rd_en, bad_flag, m_addr, m_wdata,
               e_we, e_ce, e_rd, r_flag, e_addr, e_data);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      #(CLK_P/4);
      compare();
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_idle();
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic do_write(input int a, input int d, input int len);
    b_addr = a[AW-1:0]; b_data = d[DW-1:0]; ce_n = 0; we_n = 0; oe_n = 1;
    step(len);
    bus_idle();
    step(3);
  endtask

  task automatic strobe_pwr_up();
    pwr_up = 1; step(1); pwr_up = 0; step(2);
  endtask

  initial begin
    model_reset();
    step(3);
    rst_n = 1;
    step(2);
    cur_req = "R10";
    check("R10 reset outputs", {m_we, m_ce, rd_en, bad_flag}, 0);

    cur_req = "R1";
    b_addr = 6'h15; ce_n = 0; oe_n = 0; step(3);
    check("R1 read drive", {rd_en, m_ce}, 2'b11);
    check("R1 read addr", int'(m_addr), 'h15);
    bus_idle(); step(3);

    cur_req = "R2";
    b_addr = 6'h2a; b_data = 8'h5c; ce_n = 0; we_n = 0; step(3);
    check("R2 strobe", {m_we, rd_en}, 2'b10);
    check("R2 data", int'(m_wdata), 'h5c);
    bus_idle(); step(3);

    cur_req = "R5";
    bl_in = 1; step(NS + 2);
    strobe_pwr_up();
    check("R5 flag loaded", bad_flag, 1);

    cur_req = "R11";
    bl_in = 0; step(NS + 3);
    check("R11 flag unchanged", bad_flag, 1);

    cur_req = "R7";
    b_addr = 6'h07; ce_n = 0; oe_n = 0; step(3);
    check("R7 read with flag set", rd_en, 1);
    bus_idle(); step(2);

    cur_req = "R8";
    ce_n = 1; we_n = 0; step(4);
    bus_idle(); step(2);
    check("R8 no CE not counted", bad_flag, 1);

    cur_req = "R6";
    b_addr = 6'h11; b_data = 8'ha5; ce_n = 0; we_n = 0;
    step(3);
    check("R6 first write blocked", m_we, 0);
    check("R6 flag cleared", bad_flag, 0);
    bus_idle(); step(3);

    cur_req = "R7";
    b_addr = 6'h11; b_data = 8'h3c; ce_n = 0; we_n = 0; step(3);
    check("R7 later write passes", m_we, 1);
    check("R7 data", int'(m_wdata), 'h3c);
    bus_idle(); step(3);

    cur_req = "R8";
    bl_in = 1; step(NS + 2);
    strobe_pwr_up();
    b_addr = 6'h22; b_data = 8'h99; ce_n = 0; we_n = 0; step(12);
    check("R8 long pulse blocked whole", m_we, 0);
    check("R8 counted once", bad_flag, 0);
    bus_idle(); step(3);
    bl_in = 0;

    cur_req = "R3";
    pf_in = 1; step(NS + 2);
    b_addr = 6'h3f; b_data = 8'hee; ce_n = 0; we_n = 0; step(4);
    check("R3 write suppressed", m_we, 0);
    we_n = 1; oe_n = 0; step(3);
    check("R3 read drivers off", {rd_en, m_ce}, 0);
    check("R3 addr frozen", int'(m_addr), 'h22);
    bus_idle();
    cur_req = "R9";
    bl_in = 1; step(NS + 2);
    strobe_pwr_up();
    check("R9 strobe ignored", bad_flag, 0);
    bl_in = 0; pf_in = 0; step(NS + 3);

    cur_req = "R4";
    b_addr = 6'h05; b_data = 8'h42; ce_n = 0; we_n = 0; step(3);
    check("R4 write running", m_we, 1);
    pf_in = 1; step(NS + 2);
    check("R4 aborted", m_we, 0);
    pf_in = 0; step(NS + 4);
    check("R4 no resume", m_we, 0);
    bus_idle(); step(2);
    do_write('h06, 'h43, 3);

    cur_req = "R10";
    bl_in = 1; step(NS + 2);
    strobe_pwr_up();
    ce_n = 0; oe_n = 0; step(2);
    rst_n = 0; step(1);
    check("R10 mid reset", {bad_flag, rd_en, m_ce, m_we}, 0);
    rst_n = 1; bus_idle(); bl_in = 0; step(NS + 2);

    cur_req = "R2";
    for (int i = 0; i < 1500; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r < 3) pf_in = ~pf_in;
      if (r >= 3 && r < 6) bl_in = ~bl_in;
      pwr_up = (r >= 6 && r < 9);
      if (r >= 10 && r < 40) begin
        ce_n = $urandom_range(0, 3) == 0;
        we_n = $urandom_range(0, 1) == 1;
        oe_n = $urandom_range(0, 1) == 1;
        b_addr = AW'($urandom); b_data = DW'($urandom);
      end
      step(1);
    end
    pwr_up = 0;
    step(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule